// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Overflow Chain

This block is a watchdog that runs directly from a reference clock. A 12-stage prescaler drives a 6-stage overflow counter. Together they form one 18-bit timing chain. Software has to write to a control address before the chain reaches its timeout. If it does not, the block drives an active-low reset request for a fixed number of cycles and sets a sticky watchdog flag.

A rate-select input chooses between a long and a short timeout. A service write clears only the upper stages of the chain, and the four lowest stages keep running. A phase register records where those low stages stood at the moment of service, so the timeout is exact no matter when the write lands. Counting is held in four cases:

- while the block is disabled,
- while the power-up hold is in progress,
- while the reset request is active,
- on a stop strobe, which clears the prescaler but leaves the overflow counter.

A read of the control address returns a fixed reset-vector byte. A read of the status address returns the watchdog flag, and that read clears the flag.

Top module: `wdog_timer`

## Requirements
- R1: With `rate_sel_i` = 0, if there is no further service, `rst_no` falls exactly 2^(PRE_W+CNT_W) − 16 clock edges after the edge that samples a service write. This is 262,128 at default parameters.
- R2: With `rate_sel_i` = 1, `rst_no` falls exactly 2^SHORT_BITS − 16 edges (8176) after the edge that samples a service write.
- R3: A write (`wr_i` = 1) to CTRL_ADDR clears the overflow counter and prescaler stages above the low LOW_W stages. The timeout that follows has the exact length of R1 or R2 whatever the phase of the low stages at the time of the write.
- R4: Once `rst_no` falls, it stays low for exactly PULSE_LEN (32) cycles and then returns high.
- R5: The edge on which `rst_no` falls also sets `wd_flag_o`, which stays set through the pulse. A read (`rd_i` = 1) of STAT_ADDR returns `wd_flag_o` in bit 1 of `rdata_o` with all other bits 0 on the edge that samples it. The flag then clears on the following edge.
- R6: A read of CTRL_ADDR returns VEC_LO on `rdata_o` on the edge that samples it. Reads, and writes to any address other than CTRL_ADDR, do not service the watchdog.
- R7: A `stop_i` strobe clears the prescaler, and the timeout restarts from that edge. With the overflow counter at 0 and `rate_sel_i` = 1, `rst_no` falls 8176 edges after the edge that samples `stop_i`.
- R8: After `rst_ni` is released, the chain is held at zero for POR_DLY (4096) edges. The first unserviced timeout falls at edge POR_DLY plus the R1 or R2 count.
- R9: `int_rst_i` clears the prescaler and the overflow counter, so the timeout restarts from that edge. It leaves `wd_flag_o` unchanged.
- R10: While `wd_dis_i` = 1 the chain is held at zero and `rst_no` stays high. After release, `rst_no` falls at the R1 or R2 count minus one edge, counted from the first edge that samples `wd_dis_i` = 0.
- R11: Counting is held during the reset pulse, and the chain restarts from zero when the pulse ends. Without service, the next fall comes PULSE_LEN plus the R1 or R2 count edges after the previous fall.
- R12: While `rst_ni` is low, `rst_no` = 1, `wd_flag_o` = 0 and `rdata_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| int_rst_i | input | 1 | Internal reset, clears the timing chain |
| stop_i | input | 1 | Stop-mode strobe, clears the prescaler |
| rate_sel_i | input | 1 | 1 selects the short timeout, 0 the long one |
| wd_dis_i | input | 1 | Disables the watchdog while high |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe (data is irrelevant) |
| addr_i | input | ADDR_W | Register address |
| rdata_o | output | 8 | Read data, registered |
| rst_no | output | 1 | Reset request, active low |
| wd_flag_o | output | 1 | Sticky watchdog reset flag |

## Verification
Any fault in the chain, the phase register or the clear logic shows up as the `rst_no` falling edge arriving earlier or later than expected. The bench checks the cycle right before that edge and the cycle of the edge itself, so an error of a single cycle is caught within one timeout period. Flag and read-data faults show within two cycles of a read. A wrong pulse length shows within 33 cycles of the fall.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {RSEL_NONE, RSEL_CTRL, RSEL_STAT} rsel_e;
endpackage

// File: rtl/wdog_chain.sv
module wdog_chain #(
  parameter int unsigned PRE_W      = 12,
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned LOW_W      = 4,
  parameter int unsigned SHORT_BITS = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic clr_all_i,
  input  logic clr_pre_i,
  input  logic svc_i,
  input  logic rate_i,
  output logic ovf_o
);
  localparam int unsigned CH_W = PRE_W + CNT_W;

  logic [CH_W-1:0]  ch_q, ch_d, inc;
  logic [LOW_W-1:0] ph_q, ph_d;
  logic             long_hit, short_hit, ph_match;

  assign inc = ch_q + 1'b1;

  always_comb begin
    ch_d = inc;
    ph_d = ph_q;
    if (hold_i || clr_all_i) begin
      ch_d = '0;
      ph_d = '0;
    end else if (clr_pre_i) begin
      ch_d = {ch_q[CH_W-1:PRE_W], {PRE_W{1'b0}}};
      ph_d = '0;
    end else if (svc_i) begin
      // upper stages cleared, low stages keep running; remember their phase
      ch_d = '0;
      ch_d[LOW_W-1:0] = inc[LOW_W-1:0];
      ph_d = inc[LOW_W-1:0];
    end
  end

  // overflow detected on next state so the fall lands on the exact edge
  assign long_hit  = &ch_d[CH_W-1:LOW_W];
  assign short_hit = &ch_d[SHORT_BITS-1:LOW_W];
  assign ph_match  = (ch_d[LOW_W-1:0] == ph_d);
  assign ovf_o     = !hold_i && !clr_all_i && ph_match && (rate_i ? short_hit : long_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q <= '0;
      ph_q <= '0;
    end else begin
      ch_q <= ch_d;
      ph_q <= ph_d;
    end
  end

  // R3
  svc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !hold_i && !clr_all_i && !clr_pre_i) |=>
      (ch_q[CH_W-1:LOW_W] == '0) && (ch_q[LOW_W-1:0] == ph_q));
  // R11
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i || clr_all_i) |=> (ch_q == '0) && (ph_q == '0));
  // R7
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pre_i && !hold_i && !clr_all_i) |=> (ch_q[PRE_W-1:0] == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic act_o
);
  localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == LAST) act_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;

  // R4
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(cnt_q) == LAST));
  // R11
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> !start_i);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; #(
  parameter int unsigned     ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1),
  parameter byte_t           VEC_LO    = 8'hA5,
  parameter int unsigned     FLAG_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              set_i,
  output logic              svc_o,
  output logic              flag_o,
  output byte_t             rdata_o
);
  rsel_e rsel;
  byte_t rd_mux, stat_b, rdata_q;
  logic  flag_q, rd_stat_q;

  always_comb begin
    rsel = RSEL_NONE;
    if (addr_i == CTRL_ADDR)      rsel = RSEL_CTRL;
    else if (addr_i == STAT_ADDR) rsel = RSEL_STAT;
  end

  assign svc_o = wr_i && (rsel == RSEL_CTRL);

  always_comb begin
    stat_b = '0;
    stat_b[FLAG_BIT] = flag_q;
    case (rsel)
      RSEL_CTRL: rd_mux = VEC_LO;
      RSEL_STAT: rd_mux = stat_b;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      flag_q    <= 1'b0;
      rd_stat_q <= 1'b0;
    end else begin
      rd_stat_q <= rd_i && (rsel == RSEL_STAT);
      if (rd_i) rdata_q <= rd_mux;
      if (set_i)          flag_q <= 1'b1;
      else if (rd_stat_q) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;

  // R5
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R5
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_q && !set_i) |=> !flag_q);
  // R6
  ctrl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rsel == RSEL_CTRL) |=> (rdata_o == VEC_LO));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
  parameter int unsigned       PRE_W      = 12,
  parameter int unsigned       CNT_W      = 6,
  parameter int unsigned       LOW_W      = 4,
  parameter int unsigned       SHORT_BITS = 13,
  parameter int unsigned       PULSE_LEN  = 32,
  parameter int unsigned       POR_DLY    = 4096,
  parameter int unsigned       ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = '1,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(1),
  parameter byte_t             VEC_LO     = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_rst_i,
  input  logic              stop_i,
  input  logic              rate_sel_i,
  input  logic              wd_dis_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        rdata_o,
  output logic              rst_no,
  output logic              wd_flag_o
);
  localparam int unsigned POR_W = $clog2(POR_DLY + 1);

  logic [POR_W-1:0] por_q;
  logic             por_done, pulse_act, ovf, svc, hold;

  assign por_done = (por_q == POR_W'(POR_DLY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        por_q <= '0;
    else if (!por_done) por_q <= por_q + 1'b1;
  end

  assign hold = pulse_act | wd_dis_i | ~por_done;

  wdog_chain #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .LOW_W(LOW_W), .SHORT_BITS(SHORT_BITS)
  ) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .clr_all_i(int_rst_i),
    .clr_pre_i(stop_i), .svc_i(svc), .rate_i(rate_sel_i), .ovf_o(ovf)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ovf), .act_o(pulse_act)
  );

  wdog_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR),
    .VEC_LO(VEC_LO), .FLAG_BIT(1)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .set_i(ovf), .svc_o(svc), .flag_o(wd_flag_o), .rdata_o(rdata_o)
  );

  assign rst_no = ~pulse_act;

  // R8
  por_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_done |-> rst_no);
  // R10
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_dis_i |-> !ovf);
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int PRE_W   = 12;
  localparam int CNT_W   = 2;
  localparam int SHORT_B = 13;
  localparam int PLEN    = 32;
  localparam int POR_DLY = 4096;
  localparam int N_LONG  = (1 << (PRE_W + CNT_W)) - 16;
  localparam int N_SHORT = (1 << SHORT_B) - 16;
  localparam logic [3:0] CTRL_A = 4'hF;
  localparam logic [3:0] STAT_A = 4'h1;
  localparam logic [3:0] OTHER_A = 4'h6;
  localparam logic [7:0] VEC = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, int_rst = 1'b0, stop = 1'b0, rate = 1'b1, dis = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] rdata;
  logic rst_no, flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_timer #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .LOW_W(4), .SHORT_BITS(SHORT_B),
    .PULSE_LEN(PLEN), .POR_DLY(POR_DLY), .ADDR_W(4),
    .CTRL_ADDR(CTRL_A), .STAT_ADDR(STAT_A), .VEC_LO(VEC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .int_rst_i(int_rst), .stop_i(stop),
    .rate_sel_i(rate), .wd_dis_i(dis), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .rdata_o(rdata), .rst_no(rst_no), .wd_flag_o(flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller stands at the negedge after reference edge; fall due at ref+n
  task automatic expect_fall(int n, string req);
    repeat (n - 1) @(negedge clk);
    check({req, " high one edge before timeout"}, 32'(rst_no), 1);
    @(negedge clk);
    check({req, " low at timeout"}, 32'(rst_no), 0);
  endtask

  task automatic pulse_len();
    repeat (PLEN - 1) @(negedge clk);
    check("R4 still low at last pulse cycle", 32'(rst_no), 0);
    check("R5 flag held through pulse", 32'(flag), 1);
    @(negedge clk);
    check("R4 high after pulse", 32'(rst_no), 1);
  endtask

  task automatic svc();
    wr = 1'b1; addr = CTRL_A;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R12 rst_no in reset", 32'(rst_no), 1);
    check("R12 flag in reset", 32'(flag), 0);
    check("R12 rdata in reset", 32'(rdata), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_por_and_status();
    expect_fall(POR_DLY + N_SHORT, "R8 R2");
    check("R5 flag set at fall", 32'(flag), 1);
    pulse_len();
    rd = 1'b1; addr = STAT_A;
    @(negedge clk);
    rd = 1'b0;
    check("R5 status read value", 32'(rdata), 32'h02);
    check("R5 flag still set on read edge", 32'(flag), 1);
    @(negedge clk);
    check("R5 flag cleared after read", 32'(flag), 0);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R5 status read after clear", 32'(rdata), 0);
    expect_fall(N_SHORT - 3, "R11 restart after pulse");
    pulse_len();
  endtask

  task automatic t_phase();
    svc();
    repeat (4) @(negedge clk);
    svc();
    repeat (10) @(negedge clk);
    svc();
    expect_fall(N_SHORT, "R3 R2 phase-independent timeout");
    pulse_len();
  endtask

  task automatic t_reads_no_service();
    svc();
    rd = 1'b1; addr = CTRL_A;
    @(negedge clk);
    rd = 1'b0;
    check("R6 control read value", 32'(rdata), 32'(VEC));
    wr = 1'b1; addr = STAT_A;
    @(negedge clk);
    wr = 1'b1; addr = OTHER_A;
    @(negedge clk);
    wr = 1'b0;
    expect_fall(N_SHORT - 3, "R6 no service by read or other write");
    pulse_len();
  endtask

  task automatic t_stop();
    svc();
    repeat (100) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    expect_fall(N_SHORT, "R7 stop clears prescaler");
    pulse_len();
  endtask

  task automatic t_int_rst();
    svc();
    repeat (200) @(negedge clk);
    int_rst = 1'b1;
    @(negedge clk);
    int_rst = 1'b0;
    check("R9 flag kept by internal reset", 32'(flag), 1);
    expect_fall(N_SHORT, "R9 internal reset restarts chain");
    pulse_len();
  endtask

  task automatic t_disable();
    int lows = 0;
    dis = 1'b1;
    for (int i = 0; i < N_SHORT + 500; i++) begin
      @(negedge clk);
      if (!rst_no) lows++;
    end
    check("R10 no reset while disabled", 32'(lows), 0);
    dis = 1'b0;
    @(negedge clk);
    expect_fall(N_SHORT - 1, "R10 timeout after release");
    pulse_len();
  endtask

  task automatic t_long();
    rate = 1'b0;
    svc();
    expect_fall(N_LONG, "R1 long timeout");
    pulse_len();
    rate = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_por_and_status();
    t_phase();
    t_reads_no_service();
    t_stop();
    t_int_rst();
    t_disable();
    t_long();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule